// File: doc/BRIEF.md
# Line-Scan Background Suppression Filter

This block sits between a line-scan camera's 8-bit luminance stream and a downstream compressor. It sorts every incoming pixel into two classes: defect and background. Defect pixels leave the block unchanged. Background pixels are replaced by one programmable constant. The compressor then sees long runs of a single value wherever nothing of interest appears.

A 2-bit mode input selects the rule used to sort pixels:

- a window rule that treats the inside of a band as background;
- its complement, which treats the outside of the band as background;
- a slope rule on neighbouring pixels;
- an adaptive tracker.

The tracker follows a slowly drifting background level. It uses a tolerance band around a reference level. A signed up/down counter acts as hysteresis, so the reference moves only after a run of pixels leans consistently one way.

A host writes the parameters through an eight-slot indexed write port. The output is registered and arrives with a single valid strobe.

Top module: `lsc_bg_filter`

## Requirements
- R1: A pixel is accepted on a clock edge only when `pix_valid` and `line_valid` are both high. When `cap_en` is also high, `out_valid` is high for exactly the next cycle and `out_pix` carries that pixel's result.
- R2: With `mode` = 0 (inside window), a pixel P with lo < P < hi is output as the background value. Any other pixel is output unchanged.
- R3: With `mode` = 1 (outside window), a pixel satisfying lo < P < hi is output unchanged. Every other pixel is output as the background value.
- R4: With `mode` = 2 (slope), a pixel whose absolute difference from the previous captured pixel of the line is at most the slope threshold is output as background. Otherwise it is output unchanged. The first pixel of a line is compared with itself, so it is always background.
- R5: The first accepted pixel after `line_valid` was low, or after reset, starts a line. It loads the tracker reference with that pixel and clears the drift counter. This happens even when `cap_en` is low.
- R6: With `mode` = 3 (tracker), a pixel with ref−tol < P < ref+tol is output as background. Any other pixel is output unchanged. The first pixel of a line is judged against the reference it has just loaded.
- R7: Each captured pixel that is not the first of its line moves the drift counter. It counts up if P > ref and down otherwise. When the counter reaches +W, the reference rises by one and the counter clears. When it reaches −W, the reference falls by one and the counter clears. The reference saturates at 0 and 255. W = 0 disables stepping.
- R8: While `cap_en` is low, no output strobe appears, and the slope and tracker state do not change (apart from the line start of R5).
- R9: Configuration slot encoding on `cfg_idx`: 0 background value, 1 lo, 2 hi, 3 slope threshold, 4 tolerance, 5 hysteresis W. Writes to slots 6 and 7 change nothing.
- R10: After reset, `out_valid` and `out_pix` are 0 and all configuration slots hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Camera master clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel qualifier |
| line_valid | input | 1 | Line qualifier; low between lines |
| pix_in | input | 8 | Luminance sample |
| cap_en | input | 1 | Capture enable |
| mode | input | 2 | Rule select: 0 inside, 1 outside, 2 slope, 3 tracker |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Configuration slot index |
| cfg_data | input | 8 | Configuration write data |
| out_valid | output | 1 | Output pixel strobe |
| out_pix | output | 8 | Filtered pixel |

## Verification
A corrupted tracker reference or counter does not show up at once. A wrong reference shows only when a later pixel lands near the edge of the tolerance band. So the bench places pixels exactly one step from each band edge, just after an expected reference step, and a one-count error in the reference or counter flips the class of the next pixel.

A stale previous-pixel register in slope mode shows on the first captured pixel after a capture gap. A missed line-start reload shows on the second pixel of the new line.

Strobe and latency errors show within one cycle of the accepted pixel.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    localparam int PIX_W = 8;

    typedef enum logic [1:0] {
        MODE_INSIDE  = 2'd0,
        MODE_OUTSIDE = 2'd1,
        MODE_SLOPE   = 2'd2,
        MODE_TRACK   = 2'd3
    } filt_mode_e;

    typedef struct packed {
        logic [PIX_W-1:0] bg;
        logic [PIX_W-1:0] lo;
        logic [PIX_W-1:0] hi;
        logic [PIX_W-1:0] slope_thr;
        logic [PIX_W-1:0] tol;
        logic [PIX_W-1:0] hyst;
    } filt_cfg_t;

    function automatic logic [PIX_W-1:0] abs_diff(input logic [PIX_W-1:0] a,
                                                  input logic [PIX_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction
endpackage

// File: rtl/lsc_cfg_regs.sv
module lsc_cfg_regs
    import lsc_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [PIX_W-1:0] wdata,
    output filt_cfg_t        cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (idx)
                IDX_W'(0): cfg.bg        <= wdata;
                IDX_W'(1): cfg.lo        <= wdata;
                IDX_W'(2): cfg.hi        <= wdata;
                IDX_W'(3): cfg.slope_thr <= wdata;
                IDX_W'(4): cfg.tol       <= wdata;
                IDX_W'(5): cfg.hyst      <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lsc_drift_tracker.sv
module lsc_drift_tracker
    import lsc_pkg::*;
#(
    localparam int CNT_W = PIX_W + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    init,
    input  logic                    step,
    input  logic [PIX_W-1:0]        pix,
    input  logic [PIX_W-1:0]        hyst,
    output logic [PIX_W-1:0]        ref_lvl,
    output logic signed [CNT_W-1:0] cnt
);
    localparam logic [PIX_W-1:0] PIX_MAX = {PIX_W{1'b1}};

    logic signed [CNT_W-1:0] cnt_nx;
    logic signed [CNT_W-1:0] w_pos;

    always_comb begin
        w_pos  = $signed({2'b00, hyst});
        cnt_nx = (pix > ref_lvl) ? cnt + CNT_W'(1) : cnt - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_lvl <= '0;
            cnt     <= '0;
        end else if (init) begin
            ref_lvl <= pix;
            cnt     <= '0;
        end else if (step) begin
            if (hyst != '0 && cnt_nx == w_pos) begin
                cnt <= '0;
                if (ref_lvl != PIX_MAX) ref_lvl <= ref_lvl + 1'b1;
            end else if (hyst != '0 && cnt_nx == -w_pos) begin
                cnt <= '0;
                if (ref_lvl != '0) ref_lvl <= ref_lvl - 1'b1;
            end else begin
                cnt <= cnt_nx;
            end
        end
    end
endmodule

// File: rtl/lsc_classifier.sv
module lsc_classifier
    import lsc_pkg::*;
(
    input  filt_mode_e       mode,
    input  filt_cfg_t        cfg,
    input  logic [PIX_W-1:0] pix,
    input  logic [PIX_W-1:0] prev,
    input  logic [PIX_W-1:0] ref_lvl,
    output logic [PIX_W-1:0] result
);
    logic in_win, slope_bg, band_bg, is_bg;
    logic signed [PIX_W+1:0] p_s, lo_s, hi_s;

    always_comb begin
        in_win   = (pix > cfg.lo) && (pix < cfg.hi);
        slope_bg = abs_diff(pix, prev) <= cfg.slope_thr;
        p_s      = $signed({2'b00, pix});
        lo_s     = $signed({2'b00, ref_lvl}) - $signed({2'b00, cfg.tol});
        hi_s     = $signed({2'b00, ref_lvl}) + $signed({2'b00, cfg.tol});
        band_bg  = (p_s > lo_s) && (p_s < hi_s);
        case (mode)
            MODE_INSIDE:  is_bg = in_win;
            MODE_OUTSIDE: is_bg = !in_win;
            MODE_SLOPE:   is_bg = slope_bg;
            default:      is_bg = band_bg;
        endcase
        result = is_bg ? cfg.bg : pix;
    end
endmodule

// File: rtl/lsc_bg_filter.sv
module lsc_bg_filter
    import lsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pix_valid,
    input  logic       line_valid,
    input  logic [7:0] pix_in,
    input  logic       cap_en,
    input  logic [1:0] mode,
    input  logic       cfg_we,
    input  logic [2:0] cfg_idx,
    input  logic [7:0] cfg_data,
    output logic       out_valid,
    output logic [7:0] out_pix
);
    filt_cfg_t               cfg;
    logic                    accept, capture, line_first, first_pix;
    logic [PIX_W-1:0]        prev_pix, prev_eff, ref_lvl, ref_eff, result;
    logic signed [PIX_W+1:0] trk_cnt;

    assign accept    = pix_valid && line_valid;
    assign capture   = accept && cap_en;
    assign first_pix = accept && line_first;
    assign prev_eff  = line_first ? pix_in : prev_pix;
    assign ref_eff   = line_first ? pix_in : ref_lvl;

    lsc_cfg_regs #(.SLOTS(8)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx),
        .wdata(cfg_data), .cfg(cfg)
    );

    lsc_drift_tracker u_trk (
        .clk(clk), .rst(rst), .init(first_pix),
        .step(capture && !line_first), .pix(pix_in), .hyst(cfg.hyst),
        .ref_lvl(ref_lvl), .cnt(trk_cnt)
    );

    lsc_classifier u_cls (
        .mode(filt_mode_e'(mode)), .cfg(cfg), .pix(pix_in),
        .prev(prev_eff), .ref_lvl(ref_eff), .result(result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            line_first <= 1'b1;
            prev_pix   <= '0;
            out_valid  <= 1'b0;
            out_pix    <= '0;
        end else begin
            if (!line_valid)  line_first <= 1'b1;
            else if (accept)  line_first <= 1'b0;
            if (capture)      prev_pix   <= pix_in;
            out_valid <= capture;
            if (capture)      out_pix    <= result;
        end
    end
endmodule

// File: rtl/lsc_bg_filter_chk.sv
module lsc_bg_filter_chk
    import lsc_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    pix_valid,
    input logic                    line_valid,
    input logic [7:0]              pix_in,
    input logic                    cap_en,
    input logic [1:0]              mode,
    input logic                    out_valid,
    input logic [7:0]              out_pix,
    input logic [7:0]              bg,
    input logic [7:0]              lo,
    input logic [7:0]              hi,
    input logic [7:0]              ref_lvl,
    input logic signed [9:0]       trk_cnt,
    input logic                    line_first
);
    // R1
    strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(pix_valid && line_valid && cap_en));

    // R8
    no_strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(pix_valid && line_valid && cap_en) |=> !out_valid);

    // R2
    inside_bg_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && line_valid && cap_en && mode == 2'd0 &&
         pix_in > lo && pix_in < hi) |=> (out_pix == $past(bg)));

    // R3
    outside_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && line_valid && cap_en && mode == 2'd1 &&
         pix_in > lo && pix_in < hi) |=> (out_pix == $past(pix_in)));

    // R7
    ref_step_chk: assert property (@(posedge clk) disable iff (rst)
        !(pix_valid && line_valid && line_first) |=>
        (ref_lvl == $past(ref_lvl) || ref_lvl == $past(ref_lvl) + 8'd1 ||
         ref_lvl == $past(ref_lvl) - 8'd1));

    // R7
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !(pix_valid && line_valid && line_first) && !$stable(ref_lvl) |-> trk_cnt == '0);

    // R8
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_en && !(pix_valid && line_valid && line_first) |=>
        ($stable(ref_lvl) && $stable(trk_cnt)));
endmodule

bind lsc_bg_filter lsc_bg_filter_chk u_chk (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .line_valid(line_valid),
    .pix_in(pix_in), .cap_en(cap_en), .mode(mode), .out_valid(out_valid),
    .out_pix(out_pix), .bg(cfg.bg), .lo(cfg.lo), .hi(cfg.hi),
    .ref_lvl(ref_lvl), .trk_cnt(trk_cnt), .line_first(line_first)
);

// File: tb/lsc_bg_filter_tb.sv
module lsc_bg_filter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_valid = 1'b0, line_valid = 1'b0, cap_en = 1'b0, cfg_we = 1'b0;
    logic [7:0] pix_in = '0, cfg_data = '0;
    logic [1:0] mode = '0;
    logic [2:0] cfg_idx = '0;
    logic       out_valid;
    logic [7:0] out_pix;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    lsc_bg_filter u_dut (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .line_valid(line_valid),
        .pix_in(pix_in), .cap_en(cap_en), .mode(mode), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_data(cfg_data), .out_valid(out_valid),
        .out_pix(out_pix)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_idx = idx; cfg_data = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    // drive one pixel for one cycle; check strobe and value one cycle later
    task automatic px(input string req, input logic [7:0] p, input int exp);
        @(negedge clk); pix_valid = 1'b1; pix_in = p;
        @(negedge clk); pix_valid = 1'b0;
        if (exp < 0) check({req, " no strobe"}, int'(out_valid), 0);
        else begin
            check({req, " strobe"}, int'(out_valid), 1);
            check({req, " pixel"}, int'(out_pix), exp);
            @(negedge clk);
            check({req, " strobe single"}, int'(out_valid), 0);
        end
    endtask

    task automatic new_line();
        @(negedge clk); line_valid = 1'b0;
        @(negedge clk); line_valid = 1'b1;
    endtask

    task automatic t_reset();
        check("R10 reset valid", int'(out_valid), 0);
        check("R10 reset pix", int'(out_pix), 0);
    endtask

    task automatic t_inside();
        wr(3'd0, 8'd7); wr(3'd1, 8'd50); wr(3'd2, 8'd100);
        mode = 2'd0; cap_en = 1'b1; new_line();
        px("R2 at lo", 8'd50, 50);
        px("R2 inside", 8'd51, 7);
        px("R2 inside hi", 8'd99, 7);
        px("R2 at hi", 8'd100, 100);
    endtask

    task automatic t_outside();
        mode = 2'd1;
        px("R3 at lo", 8'd50, 7);
        px("R3 inside", 8'd75, 75);
        px("R3 at hi", 8'd100, 7);
    endtask

    task automatic t_gating();
        mode = 2'd1;
        @(negedge clk); line_valid = 1'b0; pix_valid = 1'b1; pix_in = 8'd75;
        @(negedge clk); pix_valid = 1'b0;
        check("R1 line low no strobe", int'(out_valid), 0);
        line_valid = 1'b1;
    endtask

    task automatic t_slope();
        wr(3'd3, 8'd10); mode = 2'd2; new_line();
        px("R4 first", 8'd100, 7);
        px("R4 diff eq", 8'd110, 7);
        px("R4 diff over", 8'd121, 121);
        px("R4 diff small", 8'd120, 7);
        px("R4 drop", 8'd90, 90);
        cap_en = 1'b0;
        px("R8 cap off", 8'd200, -1);
        cap_en = 1'b1;
        px("R8 slope held", 8'd95, 7);
    endtask

    task automatic t_track();
        wr(3'd4, 8'd3); wr(3'd5, 8'd2); mode = 2'd3; new_line();
        px("R6 first", 8'd100, 7);
        px("R6 band", 8'd102, 7);
        px("R7 step up", 8'd103, 103);
        px("R7 after up", 8'd98, 98);
        px("R7 step down", 8'd99, 7);
        px("R7 after down", 8'd103, 103);
    endtask

    task automatic t_restart();
        new_line();
        cap_en = 1'b0;
        px("R5 init cap off", 8'd200, -1);
        cap_en = 1'b1;
        px("R5 reloaded", 8'd201, 7);
    endtask

    task automatic t_slots();
        wr(3'd6, 8'd99); wr(3'd7, 8'd99);
        mode = 2'd0;
        px("R9 bg kept", 8'd60, 7);
        px("R9 hi kept", 8'd100, 100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_inside();
        t_outside();
        t_gating();
        t_slope();
        t_track();
        t_restart();
        t_slots();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule